// File: doc/BRIEF.md
# Card Command Issue and Status Unit

This unit is the command side of a memory-card host controller. Software programs a 32-bit argument and then writes a 16-bit command word. The word names the command index, the kind of response expected, a command class, a busy flag, a transfer direction and an initialisation flag. The unit hands the index and argument to a card-side command engine over a valid/ready handshake. It then waits for that engine to return the response bytes together with a byte count. It stores the response in eight 16-bit response registers and records the outcome in a status register.

Outcomes include end of command, a special stop code, a missing or truncated response, card-reported errors and an operating-conditions busy indication. The status register is cleared by writing ones, and a 15-bit enable mask gates it onto a single interrupt line. A command of the data class also sends a one-cycle arm pulse, with its direction, to the data path.

Register access uses a simple write strobe, an address and write data. Read data is registered and follows the address one clock later.

Top module: `cardcmd_host`

## Requirements
- R1: A write to the command register (address 0) is accepted only while bit 11 of the control register (address 3) is set. A write made while that bit is clear leaves the command readback unchanged and issues no request. Command word fields: index bits 5:0, init bit 7, response type bits 10:8, busy bit 11, class bits 13:12, direction bit 15.
- R2: An accepted command clears all eight response registers. Response type 0 ends the command at request acceptance, without waiting for a response, and sets status bit 0.
- R3: A command with the init bit set and index 0 sets status bit 0 and sends no request.
- R4: The request carries the command index and the argument, whose low half is at address 1 and high half at address 2. Valid, index and argument stay steady until ready is seen.
- R5: Response bytes are paired big-endian into 16-bit words. The first pair goes to response register 7 (address 15), and register j sits at address 8+j. Bytes past the required length are stored as zero.
- R6: A response with fewer bytes than required sets status bit 7 and no completion bit. Type 2 requires 16 bytes; types 1, 3 and 6 require 4.
- R7: If no response arrives within (timeout count + 1) cycles of request acceptance, the command is treated as a short response. The timeout count is at address 6. A response arriving after that is ignored.
- R8: For type 1, with or without the busy bit, status bit 14 is set when the big-endian first four bytes ANDed with 0xFDF90000 are nonzero.
- R9: For type 6, status bit 14 is set when bytes 2..3 ANDed with 0xE008 are nonzero. For type 3, status bit 12 is set when bit 31 of the first four bytes is clear.
- R10: A complete response sets status bit 0. Index 12 also sets bit 2.
- R11: An accepted command of class 3 pulses the transfer-arm output for one cycle and presents direction bit 15 on the transfer-direction output.
- R12: The status register (address 4) resets to 0, and writing ones clears the matching bits.
- R13: The enable register (address 5) keeps bits 14:0 only. The interrupt is the OR of status ANDed with enable and updates on the same edge as status.
- R14: A command write made while a command is still in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data for reg_addr_i |
| cmd_req_valid_o | output | 1 | Command request valid |
| cmd_req_ready_i | input | 1 | Command request accepted by card side |
| cmd_req_index_o | output | 6 | Command index |
| cmd_req_arg_o | output | 32 | Command argument |
| rsp_valid_i | input | 1 | Response available (one cycle) |
| rsp_len_i | input | LEN_W | Number of response bytes returned |
| rsp_data_i | input | RSP_WORDS*16 | Response bytes, first byte in the top bits |
| xfer_arm_o | output | 1 | One-cycle pulse arming the data transfer |
| xfer_dir_o | output | 1 | Direction of the armed transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: eight response words, giving a 16-byte long response and a 5-bit length port; an 8-bit timeout count; and a 4-bit address. With eight words, a full long response covers every response register, so the word reversal can be checked from register 7 down to register 0. The bench programs a timeout count of 5, so the timeout path is reached in a few cycles and can be checked for both an early and a late sample. It also programs a larger count for ordinary commands, so that a response given in the first waiting cycle is taken ahead of the timeout.

// File: rtl/cardcmd_pkg.sv
package cardcmd_pkg;
  typedef enum logic [2:0] {RK_NONE, RK_R1, RK_R1B, RK_R2, RK_R3, RK_R6} rsp_kind_e;

  typedef struct packed {
    logic       dir;
    logic [1:0] cls;
    rsp_kind_e  kind;
    logic       init;
    logic [5:0] idx;
  } cmd_fields_t;

  localparam int A_CMD  = 0;
  localparam int A_ARGL = 1;
  localparam int A_ARGH = 2;
  localparam int A_CTRL = 3;
  localparam int A_STAT = 4;
  localparam int A_IE   = 5;
  localparam int A_CTO  = 6;
  localparam int A_RSP  = 8;

  localparam int CTRL_EN_BIT = 11;

  localparam int SB_DONE = 0;
  localparam int SB_STOP = 2;
  localparam int SB_RTO  = 7;
  localparam int SB_OCR  = 12;
  localparam int SB_CERR = 14;

  localparam logic [31:0] R1_ERRMASK = 32'hFDF9_0000;
  localparam logic [15:0] R6_ERRMASK = 16'hE008;
  localparam logic [5:0]  IDX_STOP   = 6'd12;
  localparam logic [1:0]  CLS_DATA   = 2'd3;
endpackage

// File: rtl/cardcmd_decode.sv
module cardcmd_decode
  import cardcmd_pkg::*;
(
  input  logic [15:0] word_i,
  output cmd_fields_t cmd_o
);
  always_comb begin
    cmd_o.idx  = word_i[5:0];
    cmd_o.init = word_i[7];
    cmd_o.cls  = word_i[13:12];
    cmd_o.dir  = word_i[15];
    case (word_i[10:8])
      3'd1:    cmd_o.kind = word_i[11] ? RK_R1B : RK_R1;
      3'd2:    cmd_o.kind = RK_R2;
      3'd3:    cmd_o.kind = RK_R3;
      3'd6:    cmd_o.kind = RK_R6;
      default: cmd_o.kind = RK_NONE;
    endcase
  end
endmodule

// File: rtl/cardcmd_rsp_eval.sv
module cardcmd_rsp_eval
  import cardcmd_pkg::*;
#(
  parameter int RSP_WORDS = 8,
  parameter int LEN_W     = $clog2(RSP_WORDS*2+1)
) (
  input  rsp_kind_e                  kind_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [RSP_WORDS*16-1:0]    data_i,
  output logic                       short_o,
  output logic                       cerr_o,
  output logic                       ocr_busy_o,
  output logic [RSP_WORDS*16-1:0]    words_o
);
  localparam int NB   = RSP_WORDS*2;
  localparam int NEED = 4;

  logic [LEN_W-1:0] need;
  logic [31:0]      cstat;

  assign need       = (kind_i == RK_R2) ? LEN_W'(NB) : LEN_W'(NEED);
  assign cstat      = data_i[NB*8-1 -: 32];
  assign short_o    = (kind_i != RK_NONE) && (len_i < need);
  assign ocr_busy_o = (kind_i == RK_R3) && !cstat[31];

  always_comb begin
    case (kind_i)
      RK_R1, RK_R1B: cerr_o = |(cstat & R1_ERRMASK);
      RK_R6:         cerr_o = |(cstat[15:0] & R6_ERRMASK);
      default:       cerr_o = 1'b0;
    endcase
  end

  // Byte b keeps its place; bytes past the required length read as zero.
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int HI = NB*8-1-8*b;
    assign words_o[HI -: 8] = (LEN_W'(b) < need) ? data_i[HI -: 8] : 8'h00;
  end
endmodule

// File: rtl/cardcmd_seq.sv
module cardcmd_seq #(
  parameter int CTO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             no_rsp_i,
  input  logic [CTO_W-1:0] cto_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output logic             req_valid_o,
  output logic             busy_o,
  output logic             fin_norsp_o,
  output logic             rsp_take_o,
  output logic             tmo_o
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e              st;
  logic [CTO_W-1:0] cnt;
  logic             no_rsp_q;

  assign req_valid_o = (st == S_REQ);
  assign busy_o      = (st != S_IDLE);
  assign fin_norsp_o = (st == S_REQ) && req_ready_i && no_rsp_q;
  assign rsp_take_o  = (st == S_WAIT) && rsp_valid_i;
  assign tmo_o       = (st == S_WAIT) && !rsp_valid_i && (cnt == cto_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      no_rsp_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st       <= S_REQ;
          no_rsp_q <= no_rsp_i;
        end
        S_REQ: if (req_ready_i) begin
          st  <= no_rsp_q ? S_IDLE : S_WAIT;
          cnt <= '0;
        end
        S_WAIT: begin
          if (rsp_take_o || tmo_o) st <= S_IDLE;
          else                     cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_wait_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && rsp_valid_i) |=> (st == S_IDLE));
  p_noreq_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !start_i) |=> (st == S_IDLE));
endmodule

// File: rtl/cardcmd_host.sv
module cardcmd_host
  import cardcmd_pkg::*;
#(
  parameter int RSP_WORDS = 8,
  parameter int CTO_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int LEN_W     = $clog2(RSP_WORDS*2+1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [15:0]             reg_wdata_i,
  output logic [15:0]             reg_rdata_o,
  output logic                    cmd_req_valid_o,
  input  logic                    cmd_req_ready_i,
  output logic [5:0]              cmd_req_index_o,
  output logic [31:0]             cmd_req_arg_o,
  input  logic                    rsp_valid_i,
  input  logic [LEN_W-1:0]        rsp_len_i,
  input  logic [RSP_WORDS*16-1:0] rsp_data_i,
  output logic                    xfer_arm_o,
  output logic                    xfer_dir_o,
  output logic                    irq_o
);
  localparam int RIDX_W = $clog2(RSP_WORDS);

  logic [15:0]       last_cmd_q;
  logic [31:0]       arg_q;
  logic              en_q;
  logic [15:0]       status_q, status_n, st_set, st_clr;
  logic [14:0]       ie_q, ie_n;
  logic [CTO_W-1:0]  cto_q;
  logic [15:0]       rsp_q [RSP_WORDS];
  logic [5:0]        idx_q;
  rsp_kind_e         kind_q;

  cmd_fields_t       wcmd;
  logic              wr_cmd, accept, init0, start;
  logic              busy, fin_norsp, rsp_take, tmo;
  logic              rsp_short, rsp_cerr, rsp_ocr;
  logic [RSP_WORDS*16-1:0] rsp_words;
  logic [ADDR_W-1:0] roff;
  logic              in_rsp;

  cardcmd_decode u_dec (.word_i(reg_wdata_i), .cmd_o(wcmd));

  assign wr_cmd = reg_wr_i && (reg_addr_i == ADDR_W'(A_CMD));
  assign accept = wr_cmd && en_q && !busy;
  assign init0  = wcmd.init && (wcmd.idx == 6'd0);
  assign start  = accept && !init0;

  cardcmd_seq #(.CTO_W(CTO_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .no_rsp_i(wcmd.kind == RK_NONE),
    .cto_i(cto_q), .req_ready_i(cmd_req_ready_i), .rsp_valid_i(rsp_valid_i),
    .req_valid_o(cmd_req_valid_o), .busy_o(busy), .fin_norsp_o(fin_norsp),
    .rsp_take_o(rsp_take), .tmo_o(tmo)
  );

  cardcmd_rsp_eval #(.RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) u_eval (
    .kind_i(kind_q), .len_i(rsp_len_i), .data_i(rsp_data_i),
    .short_o(rsp_short), .cerr_o(rsp_cerr), .ocr_busy_o(rsp_ocr), .words_o(rsp_words)
  );

  always_comb begin
    st_set = '0;
    if (accept && init0) st_set[SB_DONE] = 1'b1;
    if (fin_norsp) begin
      st_set[SB_DONE] = 1'b1;
      st_set[SB_STOP] = (idx_q == IDX_STOP);
    end
    if (rsp_take) begin
      if (rsp_short) st_set[SB_RTO] = 1'b1;
      else begin
        st_set[SB_DONE] = 1'b1;
        st_set[SB_STOP] = (idx_q == IDX_STOP);
        st_set[SB_CERR] = rsp_cerr;
        st_set[SB_OCR]  = rsp_ocr;
      end
    end
    if (tmo) st_set[SB_RTO] = 1'b1;
    st_clr   = (reg_wr_i && reg_addr_i == ADDR_W'(A_STAT)) ? reg_wdata_i : 16'h0000;
    status_n = (status_q & ~st_clr) | st_set;
    ie_n     = (reg_wr_i && reg_addr_i == ADDR_W'(A_IE)) ? reg_wdata_i[14:0] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd_q      <= '0;
      arg_q           <= '0;
      en_q            <= 1'b0;
      status_q        <= '0;
      ie_q            <= '0;
      cto_q           <= '0;
      idx_q           <= '0;
      kind_q          <= RK_NONE;
      cmd_req_index_o <= '0;
      cmd_req_arg_o   <= '0;
      xfer_arm_o      <= 1'b0;
      xfer_dir_o      <= 1'b0;
      irq_o           <= 1'b0;
      for (int j = 0; j < RSP_WORDS; j++) rsp_q[j] <= '0;
    end else begin
      if (reg_wr_i) begin
        if (reg_addr_i == ADDR_W'(A_ARGL)) arg_q[15:0]  <= reg_wdata_i;
        if (reg_addr_i == ADDR_W'(A_ARGH)) arg_q[31:16] <= reg_wdata_i;
        if (reg_addr_i == ADDR_W'(A_CTRL)) en_q  <= reg_wdata_i[CTRL_EN_BIT];
        if (reg_addr_i == ADDR_W'(A_CTO))  cto_q <= reg_wdata_i[CTO_W-1:0];
      end
      if (accept) begin
        last_cmd_q <= reg_wdata_i;
        idx_q      <= wcmd.idx;
        kind_q     <= wcmd.kind;
        for (int j = 0; j < RSP_WORDS; j++) rsp_q[j] <= '0;
      end
      if (start) begin
        cmd_req_index_o <= wcmd.idx;
        cmd_req_arg_o   <= arg_q;
      end
      xfer_arm_o <= start && (wcmd.cls == CLS_DATA);
      if (start && wcmd.cls == CLS_DATA) xfer_dir_o <= wcmd.dir;
      if (rsp_take && !rsp_short)
        for (int j = 0; j < RSP_WORDS; j++) rsp_q[j] <= rsp_words[16*j +: 16];
      status_q <= status_n;
      ie_q     <= ie_n;
      irq_o    <= |(status_n & {1'b0, ie_n});
    end
  end

  assign roff   = reg_addr_i - ADDR_W'(A_RSP);
  assign in_rsp = (reg_addr_i >= ADDR_W'(A_RSP)) && (32'(roff) < RSP_WORDS);

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else if (in_rsp) reg_rdata_o <= rsp_q[roff[RIDX_W-1:0]];
    else begin
      case (32'(reg_addr_i))
        A_CMD:   reg_rdata_o <= last_cmd_q;
        A_ARGL:  reg_rdata_o <= arg_q[15:0];
        A_ARGH:  reg_rdata_o <= arg_q[31:16];
        A_CTRL:  reg_rdata_o <= {4'b0, en_q, 11'b0};
        A_STAT:  reg_rdata_o <= status_q;
        A_IE:    reg_rdata_o <= {1'b0, ie_q};
        A_CTO:   reg_rdata_o <= 16'(cto_q);
        default: reg_rdata_o <= 16'h0000;
      endcase
    end
  end

  p_cmd_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !en_q && !busy) |=> (!cmd_req_valid_o && $stable(last_cmd_q)));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_req_valid_o && !cmd_req_ready_i) |=>
      (cmd_req_valid_o && $stable(cmd_req_index_o) && $stable(cmd_req_arg_o)));
  p_arm_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    xfer_arm_o |=> !xfer_arm_o);
  p_busy_ignore_r14: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && busy) |=> $stable(last_cmd_q));
  p_short_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && rsp_short) |=> status_q[SB_RTO]);
endmodule

// File: tb/tb_cardcmd_host.sv
module tb_cardcmd_host;
  localparam int RW = 8;
  localparam int LW = $clog2(RW*2+1);

  logic            clk = 1'b0;
  logic            rst;
  logic            reg_wr;
  logic [3:0]      reg_addr;
  logic [15:0]     reg_wdata, reg_rdata;
  logic            req_valid, req_ready;
  logic [5:0]      req_index;
  logic [31:0]     req_arg;
  logic            rsp_valid;
  logic [LW-1:0]   rsp_len;
  logic [RW*16-1:0] rsp_data;
  logic            xfer_arm, xfer_dir, irq;

  int checks = 0;
  int fails  = 0;
  logic [5:0]  got_idx;
  logic [31:0] got_arg;

  always #4 clk = ~clk;

  cardcmd_host dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cmd_req_valid_o(req_valid), .cmd_req_ready_i(req_ready),
    .cmd_req_index_o(req_index), .cmd_req_arg_o(req_arg),
    .rsp_valid_i(rsp_valid), .rsp_len_i(rsp_len), .rsp_data_i(rsp_data),
    .xfer_arm_o(xfer_arm), .xfer_dir_o(xfer_dir), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic serve(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 16 && !seen; i++) begin
      if (req_valid) seen = 1'b1;
      else @(negedge clk);
    end
    chk({tag, " request seen"}, 32'(seen), 32'd1);
    got_idx = req_index;
    got_arg = req_arg;
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic give(input logic [LW-1:0] n, input logic [RW*16-1:0] d);
    rsp_valid = 1'b1; rsp_len = n; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] w, input logic [LW-1:0] n,
                         input logic [RW*16-1:0] d, input string tag);
    wr(4'd4, 16'hFFFF);
    wr(4'd0, w);
    serve(tag);
    give(n, d);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd4, v);  chk("R12 status after reset", v, 16'h0000);
    rd(4'd15, v); chk("R5 rsp7 after reset", v, 16'h0000);
    chk("R13 irq after reset", irq, 1'b0);
    chk("R4 no request after reset", req_valid, 1'b0);
  endtask

  task automatic t_disabled;
    logic [15:0] v;
    wr(4'd0, 16'h0111);
    @(negedge clk);
    chk("R1 no request while disabled", req_valid, 1'b0);
    rd(4'd0, v); chk("R1 command readback unchanged", v, 16'h0000);
    wr(4'd3, 16'h0800);
    wr(4'd6, 16'h0040);
  endtask

  task automatic t_init;
    logic [15:0] v;
    wr(4'd0, 16'h0080);
    chk("R3 no request for init", req_valid, 1'b0);
    rd(4'd4, v); chk("R3 init sets done", v, 16'h0001);
    rd(4'd0, v); chk("R1 init command accepted", v, 16'h0080);
  endtask

  task automatic t_r1;
    logic [15:0] v;
    wr(4'd1, 16'h5678);
    wr(4'd2, 16'h1234);
    run_cmd(16'h0111, 5'd6, {32'h0000_0900, 96'hAABBCCDD_EEFF0011_22334455}, "R4");
    chk("R4 request index", got_idx, 6'd17);
    chk("R4 request argument", got_arg, 32'h1234_5678);
    rd(4'd15, v); chk("R5 rsp7 first pair", v, 16'h0000);
    rd(4'd14, v); chk("R5 rsp6 second pair", v, 16'h0900);
    rd(4'd13, v); chk("R5 bytes past length zero", v, 16'h0000);
    rd(4'd4, v);  chk("R10 normal completion", v, 16'h0001);
  endtask

  task automatic t_r1_err;
    logic [15:0] v;
    wr(4'd5, 16'h4000);
    run_cmd(16'h0911, 5'd6, {32'h0400_0000, 96'h0}, "R8");
    rd(4'd4, v); chk("R8 busy-variant error flag", v, 16'h4001);
    chk("R13 irq on enabled bit", irq, 1'b1);
    wr(4'd4, 16'h4000);
    chk("R13 irq drops with status", irq, 1'b0);
    rd(4'd4, v); chk("R12 write-one clears only bit 14", v, 16'h0001);
    run_cmd(16'h0111, 5'd6, {32'h0000_0900, 96'h0}, "R8");
    rd(4'd4, v); chk("R8 unmasked bits give no error", v, 16'h0001);
    wr(4'd5, 16'h0000);
  endtask

  task automatic t_r2;
    logic [15:0] v;
    run_cmd(16'h0202, 5'd16, 128'h00010203_04050607_08090A0B_0C0D0E0F, "R5");
    rd(4'd15, v); chk("R5 long rsp7", v, 16'h0001);
    rd(4'd11, v); chk("R5 long rsp3", v, 16'h0809);
    rd(4'd8, v);  chk("R5 long rsp0", v, 16'h0E0F);
    rd(4'd4, v);  chk("R10 long completion", v, 16'h0001);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0000);
    serve("R2");
    rd(4'd4, v);  chk("R2 no-response command done at accept", v, 16'h0001);
    rd(4'd15, v); chk("R2 rsp7 cleared", v, 16'h0000);
    rd(4'd8, v);  chk("R2 rsp0 cleared", v, 16'h0000);
  endtask

  task automatic t_short;
    logic [15:0] v;
    run_cmd(16'h0202, 5'd4, 128'h11223344_0, "R6");
    rd(4'd4, v);  chk("R6 short long-response", v, 16'h0080);
    rd(4'd15, v); chk("R6 short response not stored", v, 16'h0000);
  endtask

  task automatic t_timeout;
    logic [15:0] v;
    wr(4'd6, 16'h0005);
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'h0111);
    serve("R7");
    repeat (3) @(negedge clk);
    chk("R7 no timeout before count", status_bit7(), 1'b0);
    repeat (4) @(negedge clk);
    give(5'd6, {32'h1234_5678, 96'h0});
    rd(4'd4, v);  chk("R7 timeout flags short", v, 16'h0080);
    rd(4'd15, v); chk("R7 late response ignored", v, 16'h0000);
    wr(4'd6, 16'h0040);
  endtask

  function automatic logic status_bit7();
    return dut_stat_probe;
  endfunction

  // Status bit 7 observed through the interrupt line with only bit 7 enabled.
  logic dut_stat_probe;
  assign dut_stat_probe = irq;

  task automatic t_r3;
    logic [15:0] v;
    run_cmd(16'h0301, 5'd6, {32'h00FF_8000, 96'h0}, "R9");
    rd(4'd4, v); chk("R9 operating-conditions busy", v, 16'h1001);
    run_cmd(16'h0301, 5'd6, {32'h80FF_8000, 96'h0}, "R9");
    rd(4'd4, v); chk("R9 operating-conditions ready", v, 16'h0001);
  endtask

  task automatic t_r6;
    logic [15:0] v;
    run_cmd(16'h0603, 5'd6, {32'h0001_2000, 96'h0}, "R9");
    rd(4'd4, v); chk("R9 address response error", v, 16'h4001);
    run_cmd(16'h0603, 5'd6, {32'hFFFF_0100, 96'h0}, "R9");
    rd(4'd4, v); chk("R9 address response high bits unmasked", v, 16'h0001);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    run_cmd(16'h010C, 5'd6, {32'h0000_0900, 96'h0}, "R10");
    rd(4'd4, v); chk("R10 stop completion code", v, 16'h0005);
  endtask

  task automatic t_data;
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'hB111);
    chk("R11 arm pulse", xfer_arm, 1'b1);
    chk("R11 direction", xfer_dir, 1'b1);
    @(negedge clk);
    chk("R11 arm one cycle", xfer_arm, 1'b0);
    serve("R11");
    give(5'd6, {32'h0000_0900, 96'h0});
  endtask

  task automatic t_busy;
    logic [15:0] v;
    wr(4'd0, 16'h0111);
    wr(4'd0, 16'h0202);
    rd(4'd0, v); chk("R14 command while busy ignored", v, 16'h0111);
    serve("R14");
    chk("R14 index kept", got_idx, 6'd17);
    give(5'd6, {32'h0000_0900, 96'h0});
  endtask

  task automatic t_ie;
    logic [15:0] v;
    wr(4'd5, 16'hFFFF);
    rd(4'd5, v); chk("R13 enable keeps bits 14:0", v, 16'h7FFF);
    chk("R13 irq from pending done", irq, 1'b1);
    wr(4'd5, 16'h0000);
    chk("R13 irq masked", irq, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_len = '0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_init();
    t_r1();
    t_r1_err();
    t_r2();
    t_clear();
    t_short();
    wr(4'd5, 16'h0080);
    t_timeout();
    wr(4'd5, 16'h0000);
    t_r3();
    t_r6();
    t_stop();
    t_data();
    t_busy();
    t_ie();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule